// File: doc/BRIEF.md
# DS2 Frame Alignment Monitor

This block follows a serial DS2 bit stream, one bit per asserted `bit_vld`, and tracks where the framing bits sit. A framing bit recurs every `SPACING` valid bits (147 by default). Its value alternates from frame to frame, so the stream carries the framing pattern 0101... at that position. After reset the monitor is out of frame and hunts for that pattern. It watches a window of twelve neighbouring bit positions at once. Each candidate position keeps its value from the previous frame and must show the opposite value one frame later.

A candidate that shows four alternating values in a row is taken as the frame position. One more frame is then checked before the block declares itself in frame. While in frame, every framing bit is compared with the expected alternating value. Two errors among the last four framing bits put the block back out of frame.

While out of frame, an AIS request is raised for the downstream DS1 channels if the AIS mode input permits it. The request is only a flag; it does not alter any data.

The controller has three states:
- `ST_HUNT` (candidate search). Transition *hit*: a candidate completes three alternations, go to `ST_CONFIRM`.
- `ST_CONFIRM` (one-frame check). Transition *confirm-pass*: go to `ST_LOCKED`. Transition *confirm-fail*: go back to `ST_HUNT`.
- `ST_LOCKED` (in frame). Transition *loss*: the error limit is reached, go to `ST_HUNT`.

Top module: `ds2fa_monitor`

## Requirements
- R1: After reset, `oof`=1 and `in_frame`=0, and the monitor is in `ST_HUNT` with the bit position counter at 0.
- R2: A cycle with `bit_vld`=0 advances nothing: no state, position or history changes.
- R3: During the hunt, a candidate is dropped the first time it shows the same value on two successive visits one frame apart. When all twelve candidates of the window are dropped, the position counter slips back by twelve, so that the next twelve stream positions become the new window.
- R4: The *hit* transition occurs on the fourth visit of a candidate when its four values alternate, i.e. after three alternations. That position becomes the frame position.
- R5: The *confirm-pass* transition occurs when the next framing bit is the opposite of the hit value. `oof` falls, and `in_frame` rises, on the clock after that bit.
- R6: The *confirm-fail* transition occurs when that framing bit equals the hit value. The hunt then restarts with all candidates fresh and no slip.
- R7: In `ST_LOCKED`, the expected framing value toggles every frame. When a framing bit leaves two errors among the last four framing bits, `oof` rises on the next clock.
- R8: A single error among any four consecutive framing bits leaves the block in frame.
- R9: `frame_strobe` is high in exactly those cycles where `ST_LOCKED` holds, `bit_vld`=1, and the current bit is a framing bit.
- R10: `ais_req` = `oof` AND (`ais_mode` is 2'b00 or 2'b01). The values 2'b10 and 2'b11 suppress the request.
- R11: `in_frame` is always the complement of `oof`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_vld | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Serial DS2 data bit |
| ais_mode | input | 2 | AIS request enable mode; bit 1 set suppresses the request |
| oof | output | 1 | Out-of-frame alarm |
| in_frame | output | 1 | Frame alignment held |
| frame_strobe | output | 1 | The current valid bit is the framing bit (locked only) |
| ais_req | output | 1 | AIS request toward the four DS1 channels |

## Verification
`oof` and `in_frame` are registered. They change on the clock edge that takes in the deciding framing bit, so they become visible one cycle after that bit is driven. `frame_strobe` and `ais_req` are combinational and valid in the same cycle as the inputs that produce them. The bench drives each input on a falling edge and samples one time unit later. At that sample it compares the registered flags with a reference model that has not yet taken in the current bit, and the combinational outputs with the model's current position and the current inputs. Directed runs record the index of the bit after which lock is gained or lost, and compare that index with values derived by hand for the hunt, slip, confirm-fail and two-in-four cases.

// File: rtl/ds2fa_pkg.sv
package ds2fa_pkg;
    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_CONFIRM = 2'd1,
        ST_LOCKED  = 2'd2
    } fa_state_e;
endpackage

// File: rtl/ds2fa_bitpos.sv
// Position within the frame, counted in valid bits, with a backward slip
// of one candidate window on request.
module ds2fa_bitpos #(
    parameter int SPACING = 147,
    parameter int NCAND   = 12,
    parameter int PW      = $clog2(SPACING)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic          slip,
    output logic [PW-1:0] pos
);
    localparam logic [PW-1:0] LAST  = PW'(SPACING - 1);
    localparam logic [PW-1:0] WIN   = PW'(NCAND);
    localparam logic [PW-1:0] WRAPB = PW'(SPACING - NCAND);

    logic [PW-1:0] step;
    logic [PW-1:0] nxt;

    always_comb begin
        step = (pos == LAST) ? '0 : pos + PW'(1);
        if (slip) begin
            nxt = (step >= WIN) ? step - WIN : step + WRAPB;
        end else begin
            nxt = step;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos <= '0;
        end else if (adv) begin
            pos <= nxt;
        end
    end
endmodule

// File: rtl/ds2fa_hunt.sv
// Parallel candidate search: each slot checks alternation frame to frame.
module ds2fa_hunt #(
    parameter int NCAND    = 12,
    parameter int NEED_ALT = 3,
    parameter int PW       = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          adv,
    input  logic          bit_in,
    input  logic [PW-1:0] pos,
    output logic          hit,
    output logic          slip
);
    localparam int CW = $clog2(NEED_ALT + 1);

    logic [NCAND-1:0] kill_v;
    logic [NCAND-1:0] hit_v;
    logic [NCAND-1:0] alive_v;

    for (genvar k = 0; k < NCAND; k++) begin : g_cand
        logic          alive_q;
        logic          seen_q;
        logic          ref_q;
        logic [CW-1:0] cnt_q;
        logic          visit;

        assign visit    = en && adv && alive_q && (pos == PW'(k));
        assign kill_v[k] = visit && seen_q && (bit_in == ref_q);
        assign hit_v[k]  = visit && seen_q && (bit_in != ref_q)
                           && (cnt_q == CW'(NEED_ALT - 1));
        assign alive_v[k] = alive_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                alive_q <= 1'b1;
                seen_q  <= 1'b0;
                ref_q   <= 1'b0;
                cnt_q   <= '0;
            end else if (!en || slip) begin
                alive_q <= 1'b1;
                seen_q  <= 1'b0;
                ref_q   <= 1'b0;
                cnt_q   <= '0;
            end else if (visit) begin
                if (!seen_q) begin
                    seen_q <= 1'b1;
                    ref_q  <= bit_in;
                end else if (bit_in != ref_q) begin
                    ref_q <= bit_in;
                    cnt_q <= cnt_q + CW'(1);
                end else begin
                    alive_q <= 1'b0;
                end
            end
        end
    end

    assign hit  = |hit_v;
    assign slip = (|kill_v) && ((alive_v & ~kill_v) == '0);
endmodule

// File: rtl/ds2fa_errwin.sv
// Sliding history of framing-bit errors with a trip threshold.
module ds2fa_errwin #(
    parameter int WIN   = 4,
    parameter int LIMIT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic push,
    input  logic err,
    output logic trip
);
    logic [WIN-1:0] hist_q;
    logic [WIN-1:0] hist_d;

    assign hist_d = {hist_q[WIN-2:0], err};
    assign trip   = push && ($countones(hist_d) >= LIMIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (clr) begin
            hist_q <= '0;
        end else if (push) begin
            hist_q <= hist_d;
        end
    end
endmodule

// File: rtl/ds2fa_monitor.sv
module ds2fa_monitor #(
    parameter int SPACING   = 147,
    parameter int NCAND     = 12,
    parameter int NEED_ALT  = 3,
    parameter int ERR_WIN   = 4,
    parameter int ERR_LIMIT = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_vld,
    input  logic       bit_in,
    input  logic [1:0] ais_mode,
    output logic       oof,
    output logic       in_frame,
    output logic       frame_strobe,
    output logic       ais_req
);
    import ds2fa_pkg::*;

    localparam int PW = $clog2(SPACING);

    fa_state_e     state_q, state_d;
    logic [PW-1:0] pos;
    logic [PW-1:0] sel_q;
    logic          exp_q;
    logic          hit;
    logic          slip;
    logic          trip;
    logic          fbit;

    assign fbit = bit_vld && (pos == sel_q);

    ds2fa_bitpos #(.SPACING(SPACING), .NCAND(NCAND), .PW(PW)) u_pos (
        .clk  (clk),
        .rst_n(rst_n),
        .adv  (bit_vld),
        .slip (slip),
        .pos  (pos)
    );

    ds2fa_hunt #(.NCAND(NCAND), .NEED_ALT(NEED_ALT), .PW(PW)) u_hunt (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (state_q == ST_HUNT),
        .adv   (bit_vld),
        .bit_in(bit_in),
        .pos   (pos),
        .hit   (hit),
        .slip  (slip)
    );

    ds2fa_errwin #(.WIN(ERR_WIN), .LIMIT(ERR_LIMIT)) u_err (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (state_q != ST_LOCKED),
        .push (state_q == ST_LOCKED && fbit),
        .err  (bit_in != exp_q),
        .trip (trip)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT:    if (hit) state_d = ST_CONFIRM;
            ST_CONFIRM: if (fbit) state_d = (bit_in == exp_q) ? ST_LOCKED : ST_HUNT;
            ST_LOCKED:  if (trip) state_d = ST_HUNT;
            default:    state_d = ST_HUNT;
        endcase
    end

    // state register and frame-position registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            sel_q   <= '0;
            exp_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_HUNT && hit) begin
                sel_q <= pos;
                exp_q <= ~bit_in;
            end else if (state_q != ST_HUNT && fbit) begin
                exp_q <= ~exp_q;
            end
        end
    end

    // outputs
    always_comb begin
        oof          = (state_q != ST_LOCKED);
        in_frame     = (state_q == ST_LOCKED);
        frame_strobe = (state_q == ST_LOCKED) && fbit;
        ais_req      = (state_q != ST_LOCKED) && !ais_mode[1];
    end
endmodule

// File: rtl/ds2fa_monitor_chk.sv
module ds2fa_monitor_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_vld,
    input logic [1:0] ais_mode,
    input logic       oof,
    input logic       in_frame,
    input logic       frame_strobe,
    input logic       ais_req
);
    a_r11_flags_opposite: assert property (@(posedge clk) disable iff (!rst_n)
        in_frame != oof);

    a_r10_ais_needs_oof: assert property (@(posedge clk) disable iff (!rst_n)
        ais_req |-> oof);

    a_r10_ais_mode_block: assert property (@(posedge clk) disable iff (!rst_n)
        ais_mode[1] |-> !ais_req);

    a_r9_strobe_valid: assert property (@(posedge clk) disable iff (!rst_n)
        frame_strobe |-> (in_frame && bit_vld));

    a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld |=> $stable(oof));

    a_r7_oof_after_fbit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oof) |-> $past(frame_strobe));

    a_r5_lock_on_vld: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_frame) |-> $past(bit_vld));
endmodule

bind ds2fa_monitor ds2fa_monitor_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_vld     (bit_vld),
    .ais_mode    (ais_mode),
    .oof         (oof),
    .in_frame    (in_frame),
    .frame_strobe(frame_strobe),
    .ais_req     (ais_req)
);

// File: tb/ds2fa_monitor_tb.sv
module ds2fa_monitor_tb;
    localparam int S  = 20;
    localparam int NC = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_vld = 1'b0;
    logic       bit_in = 1'b0;
    logic [1:0] ais_mode = 2'b00;
    logic       oof, in_frame, frame_strobe, ais_req;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;

    // reference model state
    int   mst;            // 0 hunt, 1 confirm, 2 locked
    int   mpos, msel;
    logic mexp;
    logic [3:0] mhist;
    logic malive [NC];
    logic mseen  [NC];
    logic mref   [NC];
    int   mcnt   [NC];

    int   vcount;
    int   lock_at, loss_at;
    logic prev_inf;

    ds2fa_monitor #(.SPACING(S)) u_dut (
        .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
        .ais_mode(ais_mode), .oof(oof), .in_frame(in_frame),
        .frame_strobe(frame_strobe), .ais_req(ais_req)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at t=%0t: actual %b expected %b", req, $time, act, exp);
        end
    endtask

    task automatic check_int(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int pos_inc(input int p);
        return (p + 1) % S;
    endfunction

    task automatic cand_reset();
        for (int k = 0; k < NC; k++) begin
            malive[k] = 1'b1; mseen[k] = 1'b0; mref[k] = 1'b0; mcnt[k] = 0;
        end
    endtask

    task automatic model_reset();
        mst = 0; mpos = 0; msel = 0; mexp = 1'b0; mhist = '0;
        cand_reset();
        vcount = 0; lock_at = -1; loss_at = -1; prev_inf = 1'b0;
    endtask

    // one valid bit into the model
    task automatic model_step(input logic b);
        logic fb;
        int   np;
        int   nalive;
        fb = (mpos == msel);
        np = pos_inc(mpos);
        case (mst)
            0: begin
                if (mpos < NC && malive[mpos]) begin
                    if (!mseen[mpos]) begin
                        mseen[mpos] = 1'b1; mref[mpos] = b;
                    end else if (b != mref[mpos]) begin
                        if (mcnt[mpos] == 2) begin      // R4 hit
                            mst = 1; msel = mpos; mexp = ~b;
                            cand_reset();
                        end else begin
                            mref[mpos] = b; mcnt[mpos]++;
                        end
                    end else begin                      // R3 drop
                        malive[mpos] = 1'b0;
                        nalive = 0;
                        for (int k = 0; k < NC; k++) if (malive[k]) nalive++;
                        if (nalive == 0) begin
                            cand_reset();
                            np = (mpos + 1 - NC + S) % S;
                        end
                    end
                end
            end
            1: if (fb) begin
                if (b == mexp) begin
                    mst = 2; mexp = ~mexp; mhist = '0;
                end else begin
                    mst = 0; cand_reset();              // R6
                end
            end
            default: if (fb) begin
                mhist = {mhist[2:0], b != mexp};
                mexp  = ~mexp;
                if ($countones(mhist) >= 2) begin        // R7
                    mst = 0; cand_reset();
                end
            end
        endcase
        mpos = np;
    endtask

    task automatic drive_bit(input logic v, input logic b);
        @(negedge clk);
        bit_vld = v; bit_in = b;
        #1;
        check("R11 in_frame", in_frame, mst == 2);
        check("R7 oof", oof, mst != 2);
        check("R9 frame_strobe", frame_strobe, (mst == 2) && v && (mpos == msel));
        check("R10 ais_req", ais_req, (mst != 2) && !ais_mode[1]);
        if (in_frame && !prev_inf && lock_at < 0) lock_at = vcount - 1;
        if (!in_frame && prev_inf && loss_at < 0) loss_at = vcount - 1;
        prev_inf = in_frame;
        if (v) begin
            model_step(b);
            vcount++;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bit_vld = 1'b0;
        model_reset();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // framing value of stream bit i for a given phase; errors on listed frames
    function automatic logic fval(input int i, input int inv_a, input int inv_b, input int inv_c);
        int f;
        f = i / S;
        return logic'(f % 2) ^ (f == inv_a || f == inv_b || f == inv_c);
    endfunction

    initial begin
        logic b;
        void'($urandom(32'h5eed_0d52));
        model_reset();
        repeat (3) @(negedge clk);
        // R1 reset state, with all AIS modes
        check("R1 oof at reset", oof, 1'b1);
        check("R1 in_frame at reset", in_frame, 1'b0);
        for (int m = 0; m < 4; m++) begin
            ais_mode = 2'(m);
            #1;
            check("R10 ais mode at reset", ais_req, (m < 2));
        end
        ais_mode = 2'b00;
        rst_n = 1'b1;

        // R4/R5: phase 5, zero payload; lock after bit 5+4S
        // R8 single error at frame 6, R7 errors at frames 11 and 13
        for (int i = 0; i < 300; i++) begin
            if (i % S == 5) b = fval(i, 6, 11, 13);
            else            b = (i > 100) ? 1'($urandom) : 1'b0;
            drive_bit(1'b1, b);
        end
        check_int("R5 lock index", lock_at, 5 + 4 * S);
        check_int("R7/R8 loss index", loss_at, 5 + 13 * S);

        // R6: confirm fails on frame 4, relock after frame 9
        do_reset();
        for (int i = 0; i < 220; i++) begin
            b = (i % S == 3) ? fval(i, 4, -1, -1) : 1'b0;
            drive_bit(1'b1, b);
        end
        check_int("R6 relock after confirm fail", lock_at, 3 + 9 * S);

        // R3: phase outside first window, slip needed; R2 idle gaps ignored
        do_reset();
        for (int i = 0; i < 160; ) begin
            if ($urandom % 4 == 0) begin
                drive_bit(1'b0, 1'($urandom));
            end else begin
                b = (i % S == 15) ? fval(i, -1, -1, -1) : 1'b0;
                drive_bit(1'b1, b);
                i++;
            end
        end
        check_int("R3 lock after slip", lock_at, 115);
        check("R2 locked after idle gaps", in_frame, 1'b1);

        // random streams: random phase, payload, gaps, errors and AIS mode
        for (int run = 0; run < 4; run++) begin
            int ph;
            do_reset();
            ph = int'($urandom % S);
            for (int i = 0; i < 1500; ) begin
                if ($urandom % 8 == 0) ais_mode = 2'($urandom);
                if ($urandom % 5 == 0) begin
                    drive_bit(1'b0, 1'($urandom));
                end else begin
                    if (i % S == ph) b = logic'((i / S) % 2) ^ ($urandom % 12 == 0);
                    else             b = 1'($urandom);
                    drive_bit(1'b1, b);
                    i++;
                end
            end
        end

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule